// File: doc/BRIEF.md
# Auto-Poll Wake Controller with Bit Checker

This block duty-cycles a receiver so that it spends most of its time powered down. While in the low-power state a sleep timer runs. When it expires the receiver is powered and the block enters a polling phase. During polling it measures every mark and every space on the sliced data line in microsecond ticks and compares each width with a bit-check window. The window comes from a window code together with the demodulator bandwidth code.

The data output stays low until a run of long enough pulses is seen in a row. A run of four short pulses in a row sends the block back to sleep instead. Once the required run is seen, the block latches into continuous receive and passes the data through. It stays there even if the signal goes away, and only a new configuration write starts auto-polling again. A write with auto-polling disabled keeps the receiver permanently awake and passing data.

Top module: `autopoll_ctrl`

## Requirements
- R1: After reset the block is in continuous receive: `state_o` = 2'b10, `rx_pwr_en` = 1, and `data_out` follows `data_raw` with one clock of delay.
- R2: A configuration write (`cfg_wr` high for one clock) with `cfg_poll_en` = 0 puts the block into continuous receive from the next cycle, including when it is polling. It then never sleeps by itself.
- R3: A configuration write with `cfg_poll_en` = 1 puts the block into sleep (`state_o` = 2'b00, `rx_pwr_en` = 0) for exactly `SLEEP_UNIT_TICKS << cfg_sleep_code` ticks. It then enters polling (`state_o` = 2'b01, `rx_pwr_en` = 1).
- R4: The bit-check window in ticks is round(B / 2^bw), computed as (B + 2^bw/2) >> bw. Here bw is `cfg_bw_code`, and B for window code 0..7 is 570, 532, 494, 457, 419, 381, 343 and 305. A pulse is valid when its width is strictly greater than the window. A width equal to the window is bad.
- R5: Valid-count code 0, 1, 2 and 3 requires 0, 2, 4 and 8 consecutive valid pulses before the block leaves polling for continuous receive. Code 0 leaves polling one cycle after entering it.
- R6: `data_out` is 0 whenever the block is sleeping or polling, whatever `data_raw` does.
- R7: Four consecutive bad pulses during polling return the block to sleep.
- R8: A valid pulse clears the consecutive-bad run, and a bad pulse clears the consecutive-valid run.
- R9: Continuous receive, once reached, is kept with no data activity for any length of time. Only a configuration write leaves it.
- R10: The width counter saturates above the largest window, so a level held longer than any window counts as valid at the edge that ends it.
- R11: The first data edge after polling begins only starts a measurement and is not judged. The time spent waiting for it never counts as a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_us | input | 1 | One-cycle pulse per microsecond of timebase |
| data_raw | input | 1 | Sliced demodulated data, synchronous to clk |
| cfg_wr | input | 1 | Configuration-write strobe, restarts the controller |
| cfg_poll_en | input | 1 | 1 selects auto-polling, 0 selects always awake |
| cfg_sleep_code | input | 3 | Sleep length = SLEEP_UNIT_TICKS << code |
| cfg_win_code | input | 3 | Bit-check window selector |
| cfg_bw_code | input | 2 | Demodulator bandwidth code, scales the window |
| cfg_valid_code | input | 2 | Required consecutive valid pulses: 0/2/4/8 |
| rx_pwr_en | output | 1 | Receiver power enable, low only while sleeping |
| data_out | output | 1 | Gated data, low except in continuous receive |
| state_o | output | 2 | 00 sleep, 01 polling, 10 continuous receive |

## Verification
The assertions assume that `data_raw` is already synchronous to `clk`. They also assume that the configuration fields hold steady except in the cycle of a write, since the sleep limit and the window are read live. The stimulus changes data only on falling clock edges and changes configuration fields only together with the write strobe. It keeps `tick_us` high on every cycle, so pulse widths and sleep lengths map one-to-one onto clock cycles. With that mapping, boundary widths such as a pulse exactly equal to the window can be placed on a known cycle.

// File: rtl/autopoll_pkg.sv
package autopoll_pkg;

    typedef enum logic [1:0] {
        ST_SLEEP = 2'b00,
        ST_POLL  = 2'b01,
        ST_RECV  = 2'b10
    } ap_state_e;

    localparam int WIN_BASE_MAX = 570;
    localparam int BAD_LIMIT    = 4;
    localparam int RUN_W        = 4;

    typedef struct packed {
        ap_state_e          st;
        logic [RUN_W-1:0]   vrun;
        logic [2:0]         bad;
    } ap_regs_t;

    function automatic logic [9:0] base_window(input logic [2:0] code);
        case (code)
            3'd0:    return 10'd570;
            3'd1:    return 10'd532;
            3'd2:    return 10'd494;
            3'd3:    return 10'd457;
            3'd4:    return 10'd419;
            3'd5:    return 10'd381;
            3'd6:    return 10'd343;
            default: return 10'd305;
        endcase
    endfunction

endpackage

// File: rtl/ap_window_lut.sv
module ap_window_lut
    import autopoll_pkg::*;
#(
    parameter int WW = 10
) (
    input  logic [2:0]    win_code,
    input  logic [1:0]    bw_code,
    output logic [WW-1:0] window
);
    logic [10:0] base_ext;
    logic [10:0] half;
    logic [10:0] sum;

    always_comb begin
        base_ext = {1'b0, base_window(win_code)};
        half     = (11'd1 << bw_code) >> 1;
        sum      = (base_ext + half) >> bw_code;
        window   = WW'(sum);
    end

    always_comb begin
        a_r4_window_range: assert (sum <= 11'(WIN_BASE_MAX) && sum >= 11'd38);
    end
endmodule

// File: rtl/ap_pulse_meter.sv
module ap_pulse_meter #(
    parameter int CW  = 10,
    parameter int CAP = 571
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          tick,
    input  logic          data_in,
    output logic          data_q,
    output logic          judge,
    output logic [CW-1:0] width
);
    typedef struct packed {
        logic          data;
        logic          armed;
        logic [CW-1:0] cnt;
    } meter_t;

    meter_t s_d, s_q;
    logic   edge_seen;

    always_comb begin
        s_d       = s_q;
        edge_seen = (data_in != s_q.data);
        s_d.data  = data_in;
        if (clear) begin
            s_d.cnt   = '0;
            s_d.armed = 1'b0;
        end else if (edge_seen) begin
            s_d.cnt   = tick ? CW'(1) : '0;
            s_d.armed = 1'b1;
        end else if (tick && s_q.cnt < CW'(CAP)) begin
            s_d.cnt = s_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign data_q = s_q.data;
    assign judge  = edge_seen && s_q.armed && !clear;
    assign width  = s_q.cnt;

    a_r10_width_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= CW'(CAP));
    a_r11_unarmed_after_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !s_q.armed);
endmodule

// File: rtl/ap_sleep_timer.sv
module ap_sleep_timer #(
    parameter int UNIT = 10000,
    parameter int SCW  = 21
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       tick,
    input  logic [2:0] code,
    output logic       expire
);
    logic [SCW-1:0] cnt_d, cnt_q;
    logic [SCW-1:0] limit;

    always_comb begin
        limit  = SCW'(UNIT) << code;
        expire = run && tick && (cnt_q == limit - SCW'(1));
        cnt_d  = cnt_q;
        if (!run)        cnt_d = '0;
        else if (expire) cnt_d = '0;
        else if (tick)   cnt_d = cnt_q + SCW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/autopoll_ctrl.sv
module autopoll_ctrl
    import autopoll_pkg::*;
#(
    parameter int SLEEP_UNIT_TICKS = 10000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_us,
    input  logic       data_raw,
    input  logic       cfg_wr,
    input  logic       cfg_poll_en,
    input  logic [2:0] cfg_sleep_code,
    input  logic [2:0] cfg_win_code,
    input  logic [1:0] cfg_bw_code,
    input  logic [1:0] cfg_valid_code,
    output logic       rx_pwr_en,
    output logic       data_out,
    output logic [1:0] state_o
);
    localparam int WCAP = WIN_BASE_MAX + 1;
    localparam int CW   = $clog2(WCAP + 1);
    localparam int SCW  = $clog2(SLEEP_UNIT_TICKS * 128 + 1);

    ap_regs_t         r_d, r_q;
    logic [CW-1:0]    window;
    logic [CW-1:0]    m_width;
    logic             m_judge;
    logic             m_data;
    logic             pulse_ok;
    logic             sleep_done;
    logic [RUN_W-1:0] need;
    logic [RUN_W-1:0] vrun_inc;

    ap_window_lut #(.WW(CW)) u_lut (
        .win_code (cfg_win_code),
        .bw_code  (cfg_bw_code),
        .window   (window)
    );

    ap_pulse_meter #(.CW(CW), .CAP(WCAP)) u_meter (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (r_q.st != ST_POLL),
        .tick    (tick_us),
        .data_in (data_raw),
        .data_q  (m_data),
        .judge   (m_judge),
        .width   (m_width)
    );

    ap_sleep_timer #(.UNIT(SLEEP_UNIT_TICKS), .SCW(SCW)) u_sleep (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (r_q.st == ST_SLEEP && !cfg_wr),
        .tick   (tick_us),
        .code   (cfg_sleep_code),
        .expire (sleep_done)
    );

    always_comb begin
        need     = (cfg_valid_code == 2'd0) ? '0 : (RUN_W'(1) << cfg_valid_code);
        pulse_ok = m_width > window;
        vrun_inc = r_q.vrun + RUN_W'(1);
        r_d      = r_q;
        case (r_q.st)
            ST_SLEEP: begin
                if (sleep_done) begin
                    r_d.st   = ST_POLL;
                    r_d.vrun = '0;
                    r_d.bad  = '0;
                end
            end
            ST_POLL: begin
                if (need == '0) begin
                    r_d.st = ST_RECV;
                end else if (m_judge) begin
                    if (pulse_ok) begin
                        r_d.bad = '0;
                        if (vrun_inc >= need) begin
                            r_d.st   = ST_RECV;
                            r_d.vrun = '0;
                        end else begin
                            r_d.vrun = vrun_inc;
                        end
                    end else begin
                        r_d.vrun = '0;
                        if (r_q.bad == 3'(BAD_LIMIT - 1)) begin
                            r_d.st  = ST_SLEEP;
                            r_d.bad = '0;
                        end else begin
                            r_d.bad = r_q.bad + 3'd1;
                        end
                    end
                end
            end
            default: r_d.st = ST_RECV;
        endcase
        if (cfg_wr) begin
            r_d.st   = cfg_poll_en ? ST_SLEEP : ST_RECV;
            r_d.vrun = '0;
            r_d.bad  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st   <= ST_RECV;
            r_q.vrun <= '0;
            r_q.bad  <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rx_pwr_en = (r_q.st != ST_SLEEP);
    assign data_out  = (r_q.st == ST_RECV) && m_data;
    assign state_o   = r_q.st;

    a_r7_bad_run_sleeps: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_POLL && !cfg_wr && need != '0 && m_judge && !pulse_ok
         && r_q.bad == 3'(BAD_LIMIT - 1)) |=> state_o == 2'b00);
    a_r5_release_on_run: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_POLL && !cfg_wr && m_judge && pulse_ok && vrun_inc >= need)
        |=> state_o == 2'b10);
    a_r8_runs_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(r_q.vrun != '0 && r_q.bad != '0));
    a_r9_receive_latched: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'b10 && !cfg_wr) |=> state_o == 2'b10);
    a_r3_sleep_exits_to_poll: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'b00 && !cfg_wr) |=> state_o != 2'b10);
    a_r6_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_pwr_en |-> !data_out);
endmodule

// File: tb/autopoll_ctrl_test.sv
module autopoll_ctrl_test;
    localparam int UNIT = 200;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_us = 1'b1;
    logic       data_raw = 1'b0;
    logic       cfg_wr = 1'b0;
    logic       cfg_poll_en = 1'b0;
    logic [2:0] cfg_sleep_code = '0;
    logic [2:0] cfg_win_code = '0;
    logic [1:0] cfg_bw_code = '0;
    logic [1:0] cfg_valid_code = '0;
    logic       rx_pwr_en;
    logic       data_out;
    logic [1:0] state_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        string      tag;
        logic [1:0] st;
        logic       dout;
        bit         chk_dout;
    } exp_t;
    exp_t sb_q[$];

    always #2.5 clk = ~clk;

    autopoll_ctrl #(.SLEEP_UNIT_TICKS(UNIT)) uut (
        .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .data_raw(data_raw),
        .cfg_wr(cfg_wr), .cfg_poll_en(cfg_poll_en), .cfg_sleep_code(cfg_sleep_code),
        .cfg_win_code(cfg_win_code), .cfg_bw_code(cfg_bw_code),
        .cfg_valid_code(cfg_valid_code), .rx_pwr_en(rx_pwr_en),
        .data_out(data_out), .state_o(state_o)
    );

    function automatic int bench_window(input int wc, input int bw);
        int base [8] = '{570, 532, 494, 457, 419, 381, 343, 305};
        return (base[wc] + ((1 << bw) / 2)) >> bw;
    endfunction

    task automatic expect_now(input string tag, input logic [1:0] st,
                              input logic dout, input bit chk_dout);
        exp_t e;
        e.tag = tag; e.st = st; e.dout = dout; e.chk_dout = chk_dout;
        sb_q.push_back(e);
    endtask

    task automatic write_cfg(input logic en, input logic [2:0] sc, input logic [2:0] wc,
                             input logic [1:0] bw, input logic [1:0] vc);
        @(negedge clk);
        cfg_poll_en = en; cfg_sleep_code = sc; cfg_win_code = wc;
        cfg_bw_code = bw; cfg_valid_code = vc; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic toggle_hold(input int w);
        @(negedge clk);
        data_raw = ~data_raw;
        repeat (w) @(posedge clk);
        #1;
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // monitor: pops expectations and compares against the ports
    initial begin
        forever begin
            exp_t e;
            logic exp_pwr;
            wait (sb_q.size() != 0);
            e = sb_q.pop_front();
            exp_pwr = (e.st != 2'b00);
            checks++;
            if (state_o !== e.st || rx_pwr_en !== exp_pwr ||
                (e.chk_dout && data_out !== e.dout)) begin
                failures++;
                $display("FAIL %s: state=%b pwr=%b dout=%b expected state=%b pwr=%b dout=%b",
                         e.tag, state_o, rx_pwr_en, data_out, e.st, exp_pwr, e.dout);
            end
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: run not finished, expected completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        wait_cycles(1);
        expect_now("R1 reset state", 2'b10, 1'b0, 1'b1);
        @(negedge clk) data_raw = 1'b1;
        wait_cycles(1);
        expect_now("R1 passthrough", 2'b10, 1'b1, 1'b1);

        // R2: awake configuration never sleeps
        write_cfg(1'b0, 3'd0, 3'd0, 2'd0, 2'd1);
        wait_cycles(3000);
        expect_now("R2 stays awake", 2'b10, 1'b1, 1'b1);
        toggle_hold(1);
        expect_now("R2 data follows", 2'b10, 1'b0, 1'b1);

        // R3 sleep length (code 1), R6, R11, R5 with code 01
        @(negedge clk) data_raw = 1'b1;
        write_cfg(1'b1, 3'd1, 3'd0, 2'd0, 2'd1);
        repeat (2 * UNIT - 1) @(posedge clk);
        #1 expect_now("R3 R6 still asleep", 2'b00, 1'b0, 1'b1);
        wait_cycles(1);
        expect_now("R3 enters polling", 2'b01, 1'b0, 1'b1);
        wait_cycles(700);
        expect_now("R6 held low while polling", 2'b01, 1'b0, 1'b1);
        toggle_hold(600);
        toggle_hold(600);
        expect_now("R11 arming edge not counted", 2'b01, 1'b0, 1'b1);
        toggle_hold(10);
        expect_now("R5 two valid release", 2'b10, 1'b0, 1'b0);
        wait_cycles(5000);
        expect_now("R9 latched without activity", 2'b10, data_raw, 1'b1);
        toggle_hold(1);
        expect_now("R9 data passes", 2'b10, data_raw, 1'b1);

        // R7 / R8: bad run cleared by a valid pulse, then four bad -> sleep
        write_cfg(1'b1, 3'd0, 3'd3, 2'd1, 2'd2);
        wait_cycles(UNIT + 50);
        expect_now("R3 polling again", 2'b01, 1'b0, 1'b1);
        toggle_hold(100);
        toggle_hold(100);
        toggle_hold(bench_window(3, 1) + 70);
        toggle_hold(100);
        toggle_hold(100);
        toggle_hold(100);
        toggle_hold(100);
        expect_now("R8 valid cleared bad run", 2'b01, 1'b0, 1'b1);
        toggle_hold(100);
        expect_now("R7 four bad -> sleep", 2'b00, 1'b0, 1'b1);

        // R8: valid run cleared by a bad pulse
        wait_cycles(UNIT + 50);
        expect_now("R3 poll after bad run", 2'b01, 1'b0, 1'b1);
        toggle_hold(300);
        toggle_hold(300);
        toggle_hold(300);
        toggle_hold(100);
        toggle_hold(300);
        toggle_hold(300);
        toggle_hold(300);
        toggle_hold(300);
        expect_now("R8 bad cleared valid run", 2'b01, 1'b0, 1'b1);
        toggle_hold(10);
        expect_now("R5 four valid release", 2'b10, 1'b0, 1'b0);

        // R10: long level saturates and counts as valid
        write_cfg(1'b1, 3'd0, 3'd0, 2'd0, 2'd1);
        wait_cycles(UNIT + 50);
        toggle_hold(1100);
        toggle_hold(600);
        expect_now("R10 one valid so far", 2'b01, 1'b0, 1'b1);
        toggle_hold(10);
        expect_now("R10 saturated width valid", 2'b10, 1'b0, 1'b0);

        // R4: width equal to window is bad, one more is valid
        write_cfg(1'b1, 3'd0, 3'd7, 2'd3, 2'd1);
        wait_cycles(UNIT + 50);
        toggle_hold(bench_window(7, 3));
        toggle_hold(bench_window(7, 3) + 1);
        toggle_hold(bench_window(7, 3) + 1);
        expect_now("R4 equal width is bad", 2'b01, 1'b0, 1'b1);
        toggle_hold(5);
        expect_now("R4 window+1 valid", 2'b10, 1'b0, 1'b0);

        // R5: eight valid required
        write_cfg(1'b1, 3'd0, 3'd0, 2'd3, 2'd3);
        wait_cycles(UNIT + 50);
        for (int i = 0; i < 8; i++) toggle_hold(bench_window(0, 3) + 9);
        expect_now("R5 seven valid not enough", 2'b01, 1'b0, 1'b1);
        toggle_hold(5);
        expect_now("R5 eight valid release", 2'b10, 1'b0, 1'b0);

        // R5: zero valid required
        write_cfg(1'b1, 3'd0, 3'd0, 2'd0, 2'd0);
        repeat (UNIT - 1) @(posedge clk);
        #1 expect_now("R3 sleep length code 0", 2'b00, 1'b0, 1'b1);
        wait_cycles(1);
        expect_now("R5 code0 polls one cycle", 2'b01, 1'b0, 1'b1);
        wait_cycles(1);
        expect_now("R5 code0 releases", 2'b10, 1'b0, 1'b0);

        // R2: disabling write during polling wakes the block at once
        write_cfg(1'b1, 3'd0, 3'd0, 2'd0, 2'd1);
        wait_cycles(UNIT + 50);
        expect_now("R3 polling before disable", 2'b01, 1'b0, 1'b1);
        write_cfg(1'b0, 3'd0, 3'd0, 2'd0, 2'd1);
        expect_now("R2 disable write wakes", 2'b10, data_raw, 1'b1);

        wait (sb_q.size() == 0);
        #1;
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule